// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the address sequence for a synchronous burst memory. A full external address is captured whenever either of two burst-start strobes is high at a rising clock edge: one strobe belongs to the processor side and the other to the memory controller side, and the two have equal standing. After the capture, the low-order bits come from an internal beat counter. That counter moves one step on each rising edge where the advance input is high and no strobe is present. The upper address bits stay at their captured value for the whole burst.

A static order input picks how the beat number maps onto the low address bits. In linear order the captured low bits count upward and wrap. In interleaved order the captured low bits are XORed with the beat number. The block also reports the current beat position and flags the final beat of the four.

Bursting is optional. A fresh external address may be strobed in on every clock, and each one appears at the output one cycle later with no extra latency. The counter width, the address width and the set of supported orders are parameters. By default the counter is two bits wide, and both orders are available and chosen at run time by the order pin.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_out` is 0, `beat_idx` is 0 and `burst_last` is 0.
- R2: When `start_cpu` is 1 at a rising edge, `addr_out` equals the `ext_addr` sampled at that edge from the next cycle on, and `beat_idx` is 0.
- R3: When `start_ctl` is 1 at a rising edge, it behaves exactly like `start_cpu`: it loads `ext_addr` and clears `beat_idx` to 0.
- R4: When a start strobe and `adv` are both 1 at the same edge, the load takes effect and `adv` is ignored: `beat_idx` becomes 0, not 1.
- R5: When `adv` is 1 and both strobes are 0 at an edge, `beat_idx` increases by one modulo 4, so it wraps from 3 to 0.
- R6: With `seq_linear` = 1 (linear order), `addr_out[1:0]` = (captured low bits + `beat_idx`) mod 4. `addr_out[ADDR_W-1:2]` keep their captured value.
- R7: With `seq_linear` = 0 (interleaved order, which is the tie-off default), `addr_out[1:0]` = captured low bits XOR `beat_idx`. The upper bits are unchanged.
- R8: When both strobes and `adv` are 0 at an edge, `beat_idx` and `addr_out` keep their values.
- R9: `burst_last` is 1 exactly when `beat_idx` is 3, the fourth beat of a burst.
- R10: Loads on consecutive cycles (alternating between the two strobes) each present their own address on the cycle that follows, with no dead cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ext_addr | input | ADDR_W | External address captured on a burst start |
| start_cpu | input | 1 | Processor-side burst-start strobe |
| start_ctl | input | 1 | Controller-side burst-start strobe |
| adv | input | 1 | Step to the next beat of the burst |
| seq_linear | input | 1 | Order select: 1 linear, 0 interleaved |
| addr_out | output | ADDR_W | Current full address |
| beat_idx | output | CNT_W | Beat position within the burst |
| burst_last | output | 1 | High on the final beat of the burst |

## Verification
Full four-beat bursts are run in each order from every starting low-bit value. This separates the additive map from the XOR map: the two agree only on some beats, and a start at 0 alone cannot tell them apart. Advance is interleaved with idle cycles, so that holding can be distinguished from stepping. A strobe is raised together with advance to expose a wrong priority. Both strobes are used back-to-back with changing addresses, which shows whether each strobe captures its own address in the cycle that follows it.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } burst_act_e;

   localparam int ORDER_PIN    = 0;
   localparam int ORDER_LINEAR = 1;
   localparam int ORDER_XOR    = 2;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
   import burst_addr_pkg::*;
(
   input  logic       start_cpu,
   input  logic       start_ctl,
   input  logic       adv,
   output burst_act_e act
);

   logic any_start;

   assign any_start = start_cpu | start_ctl;

   // A start strobe takes priority over advance.
   always_comb begin
      if (any_start)
         act = ACT_LOAD;
      else if (adv)
         act = ACT_STEP;
      else
         act = ACT_HOLD;
   end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   generate
      if (ADDR_W < 1) begin : g_bad_w
         $error("burst_base_reg: ADDR_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_addr_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  burst_act_e       act,
   output logic [CNT_W-1:0] beat,
   output logic             last
);

   localparam logic [CNT_W-1:0] BEAT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] BEAT_LAST = {CNT_W{1'b1}};

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("burst_beat_ctr: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         beat <= '0;
      else begin
         unique case (act)
            ACT_LOAD: beat <= '0;
            ACT_STEP: beat <= beat + BEAT_ONE;
            default:  beat <= beat;
         endcase
      end
   end

   assign last = (beat == BEAT_LAST);

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_addr_pkg::*;
#(
   parameter int CNT_W      = 2,
   parameter int ORDER_MODE = ORDER_PIN
) (
   input  logic [CNT_W-1:0] base_lo,
   input  logic [CNT_W-1:0] beat,
   input  logic             seq_linear,
   output logic [CNT_W-1:0] lo_out
);

   logic [CNT_W-1:0] lin_lo;
   logic [CNT_W-1:0] xor_lo;

   assign lin_lo = base_lo + beat;
   assign xor_lo = base_lo ^ beat;

   generate
      if (ORDER_MODE == ORDER_PIN) begin : g_pin
         assign lo_out = seq_linear ? lin_lo : xor_lo;
      end else if (ORDER_MODE == ORDER_LINEAR) begin : g_lin
         logic unused_sel;
         logic [CNT_W-1:0] unused_xor;
         assign unused_sel = seq_linear;
         assign unused_xor = xor_lo;
         assign lo_out     = lin_lo;
      end else if (ORDER_MODE == ORDER_XOR) begin : g_xor
         logic unused_sel;
         logic [CNT_W-1:0] unused_lin;
         assign unused_sel = seq_linear;
         assign unused_lin = lin_lo;
         assign lo_out     = xor_lo;
      end else begin : g_bad_mode
         $error("burst_order_map: ORDER_MODE out of range");
         assign lo_out = xor_lo;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int CNT_W      = 2,
   parameter int ORDER_MODE = ORDER_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              start_cpu,
   input  logic              start_ctl,
   input  logic              adv,
   input  logic              seq_linear,
   output logic [ADDR_W-1:0] addr_out,
   output logic [CNT_W-1:0]  beat_idx,
   output logic              burst_last
);

   localparam int HI_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1 || CNT_W >= ADDR_W) begin : g_bad_split
         $error("burst_addr_gen: need 1 <= CNT_W < ADDR_W");
      end
   endgenerate

   burst_act_e       act;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  lo_mapped;

   burst_cmd_decode u_dec (
      .start_cpu (start_cpu),
      .start_ctl (start_ctl),
      .adv       (adv),
      .act       (act)
   );

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (act == ACT_LOAD),
      .d     (ext_addr),
      .q     (base_q)
   );

   burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .beat  (beat_idx),
      .last  (burst_last)
   );

   burst_order_map #(.CNT_W(CNT_W), .ORDER_MODE(ORDER_MODE)) u_map (
      .base_lo    (base_q[CNT_W-1:0]),
      .beat       (beat_idx),
      .seq_linear (seq_linear),
      .lo_out     (lo_mapped)
   );

   assign addr_out = {base_q[ADDR_W-1 -: HI_W], lo_mapped};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              start_cpu,
   input logic              start_ctl,
   input logic              adv,
   input logic              seq_linear,
   input logic [ADDR_W-1:0] addr_out,
   input logic [CNT_W-1:0]  beat_idx,
   input logic              burst_last
);

   logic [CNT_W-1:0] lo;
   logic             strobe;
   assign lo     = addr_out[CNT_W-1:0];
   assign strobe = start_cpu | start_ctl;

   assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_cpu && (seq_linear == 1'b1 || seq_linear == 1'b0)) |=>
         (beat_idx == '0 && (addr_out == $past(ext_addr) || !$stable(seq_linear))));

   assert_ctl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_ctl |=> (beat_idx == '0 && (addr_out == $past(ext_addr) || !$stable(seq_linear))));

   assert_start_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && adv) |=> (beat_idx == '0));

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && adv) |=> (beat_idx == CNT_W'($past(beat_idx) + 1'b1)));

   assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && seq_linear) |=>
         (!seq_linear || CNT_W'(lo - beat_idx) == $past(CNT_W'(lo - beat_idx))));

   assert_xor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !seq_linear) |=>
         (seq_linear || (lo ^ beat_idx) == $past(lo ^ beat_idx)));

   assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !adv) |=> $stable(beat_idx));

   assert_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && adv && beat_idx == {CNT_W{1'b1}} - 1'b1) |=> burst_last);

   assert_first_not_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !burst_last);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_addr   (ext_addr),
   .start_cpu  (start_cpu),
   .start_ctl  (start_ctl),
   .adv        (adv),
   .seq_linear (seq_linear),
   .addr_out   (addr_out),
   .beat_idx   (beat_idx),
   .burst_last (burst_last)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 20;

   typedef struct {
      logic [AW-1:0] addr;
      logic [1:0]    beat;
      logic          last;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          start_cpu = 1'b0;
   logic          start_ctl = 1'b0;
   logic          adv = 1'b0;
   logic          seq_linear = 1'b0;
   logic [AW-1:0] addr_out;
   logic [1:0]    beat_idx;
   logic          burst_last;

   int n_vec = 0;
   int n_bad = 0;
   exp_t exp_q[$];

   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
      .start_cpu(start_cpu), .start_ctl(start_ctl), .adv(adv),
      .seq_linear(seq_linear), .addr_out(addr_out),
      .beat_idx(beat_idx), .burst_last(burst_last)
   );

   task automatic check(input string tag, input logic [AW-1:0] a,
                        input logic [1:0] b, input logic l);
      n_vec++;
      if (addr_out !== a || beat_idx !== b || burst_last !== l) begin
         n_bad++;
         $display("FAIL %s: got addr=%h beat=%0d last=%0b, expected addr=%h beat=%0d last=%0b",
                  tag, addr_out, beat_idx, burst_last, a, b, l);
      end
   endtask

   // Driver: one vector per cycle, expected result pushed to the scoreboard.
   task automatic drive(input string tag, input logic cpu, input logic ctl,
                        input logic ad, input logic lin, input logic [AW-1:0] a);
      exp_t e;
      @(negedge clk);
      start_cpu = cpu; start_ctl = ctl; adv = ad; seq_linear = lin; ext_addr = a;
      if (cpu || ctl) begin
         m_base = a; m_cnt = 2'd0;
      end else if (ad) begin
         m_cnt = m_cnt + 2'd1;
      end
      e.addr = {m_base[AW-1:2], lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
      e.beat = m_cnt;
      e.last = (m_cnt == 2'd3);
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compares shortly after the edge that applied each vector.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, e.addr, e.beat, e.last);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1 reset", '0, 2'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R5 R6 R9: linear bursts from every low-bit start
      for (int s = 0; s < 4; s++) begin
         drive("R2 cpu load", 1, 0, 0, 1, 20'hA5C30 | AW'(s));
         for (int k = 0; k < 4; k++)
            drive("R5 R6 R9 linear step", 0, 0, 1, 1, 20'h0FFFF);
      end

      // R8: hold with idle cycles mid-burst
      drive("R2 cpu load", 1, 0, 0, 1, 20'h12346);
      drive("R6 step", 0, 0, 1, 1, 20'h0);
      drive("R8 hold", 0, 0, 0, 1, 20'hFFFFF);
      drive("R8 hold", 0, 0, 0, 1, 20'h00001);
      drive("R6 step", 0, 0, 1, 1, 20'h0);

      // R3 R7: interleaved bursts via controller strobe
      for (int s = 0; s < 4; s++) begin
         drive("R3 ctl load", 0, 1, 0, 0, 20'h5_0000 | AW'(s) | 20'h00340);
         for (int k = 0; k < 5; k++)
            drive("R7 R9 xor step", 0, 0, 1, 0, 20'hFFFFF);
      end

      // R4: strobe with advance mid-burst
      drive("R3 ctl load", 0, 1, 0, 0, 20'h77771);
      drive("R7 step", 0, 0, 1, 0, 20'h0);
      drive("R4 start+adv", 1, 0, 1, 0, 20'h88882);
      drive("R4 start+adv", 0, 1, 1, 1, 20'h99993);
      drive("R6 step", 0, 0, 1, 1, 20'h0);

      // R10: back-to-back loads alternating strobes
      for (int k = 0; k < 8; k++)
         drive("R10 back-to-back", (k % 2) == 0, (k % 2) == 1, k[0], k[1], AW'(32'h3_1000 + k * 32'h1357));

      // R8: long hold
      for (int k = 0; k < 3; k++)
         drive("R8 hold", 0, 0, 0, 0, AW'(k * 32'h11111));

      drive("R8 hold", 0, 0, 0, 0, 20'h0);
      @(posedge clk);
      #3;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule